// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block is an integer address unit. It keeps a small file of 32-bit registers that hold pointers, modifiers, buffer bases and buffer lengths. Each request names a pointer register, a modifier (a signed immediate or a register), an addressing mode and an update kind. The unit returns one memory address and may write the updated pointer back into the file. The request's access size (one, two or four words) travels with the address as a tag, so the memory side knows how many words to move.

Three pointer updates are supported. The linear update adds the modifier. The circular update wraps inside a buffer that can start at any base and have any length. The bit-reversed update adds the modifier with the carry running from the top bit down to bit 0. This gives the reordered index sequence that a radix-2 FFT needs. Each request's address appears on a registered output one cycle after the request, together with a valid strobe. A request issued in the next cycle sees the pointer that was written back, so no stall is needed.

Top module: `addr_gen`

## Requirements
- R1: A request sampled at a clock edge with `reqValid` high gives `addrValid` high with its address on `addrOut` after that edge. `addrValid` is low after any edge without a request, and `addrOut` and `addrSize` then keep their last values.
- R2: The register file has entries 0 to 30, loaded through `wrEn`/`wrIdx`/`wrData`. A load is visible to a request in the next cycle. Index 31 always reads as zero, whether it is used as a pointer or as a modifier, and a load to index 31 has no effect.
- R3: With `reqModSel`=0 the modifier is the signed immediate `reqImm`. With `reqModSel`=1 it is the register named by `reqModIdx`.
- R4: `reqMode` 00 (direct) outputs the pointer unchanged and writes nothing. 01 (indexed) outputs the updated value and writes nothing.
- R5: `reqMode` 10 (pre-modify) outputs the updated value and writes it back to the pointer register.
- R6: `reqMode` 11 (post-modify) outputs the old pointer and writes the updated value back.
- R7: `reqUpd` 00 is the linear update, pointer plus modifier modulo 2^32. The spare code 11 also acts as linear.
- R8: `reqUpd` 01 is circular for pointers 0 to 3. Pointer j uses base register 23+j and length register 27+j. If pointer plus modifier is at or above base+length, the length is subtracted. If it is below base, the length is added. The pointer must lie inside the buffer, and the modifier magnitude must not exceed the length.
- R9: A circular request on a pointer at index 4 or above uses the linear update.
- R10: `reqUpd` 10 is bit-reversed: pointer plus modifier with the carry propagating from bit 31 toward bit 0. Any carry out of bit 0 is dropped.
- R11: `addrSize` carries the request's size code: 00 single, 01 dual, 10 quad. Code 11 is delivered as 10.
- R12: When a load and a write-back target the same register in one cycle, the write-back wins. When they target different registers, both take effect.
- R13: During reset, `addrValid`, `addrOut` and `addrSize` are zero and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register load strobe |
| wrIdx | input | 5 | Register load index |
| wrData | input | 32 | Register load value |
| reqValid | input | 1 | Request strobe |
| reqPtr | input | 5 | Pointer register index |
| reqModSel | input | 1 | 0: immediate modifier, 1: register modifier |
| reqModIdx | input | 5 | Modifier register index |
| reqImm | input | 32 | Signed immediate modifier |
| reqMode | input | 2 | Addressing mode |
| reqUpd | input | 2 | Update kind |
| reqSize | input | 2 | Access size code |
| addrValid | output | 1 | Address valid strobe |
| addrOut | output | 32 | Generated address |
| addrSize | output | 2 | Access size tag |

## Verification
The assertions check the cycle-level rules on every cycle. They check that the valid strobe follows the request one edge later and that the address is held when no request arrives. They check that the size tag is mapped correctly. They check that two back-to-back linear post-modify requests on one pointer give addresses that differ by the first immediate. They check that repeated direct reads with no load in between return the same address. The bench scenarios cover the rest: the circular wrap in both directions and on a pre-modify, the fallback to linear above pointer 3, the bit-reversed index sequence, the behaviour of index 31, and the priority of write-back over a load.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_INDEX  = 2'b01,
    MODE_PRE    = 2'b10,
    MODE_POST   = 2'b11
  } addrMode_e;

  typedef enum logic [1:0] {
    UPD_LINEAR = 2'b00,
    UPD_CIRC   = 2'b01,
    UPD_BITREV = 2'b10,
    UPD_SPARE  = 2'b11
  } updKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     fire;
    logic     writeBack;
    logic     emitOld;
    logic     useRegMod;
    updKind_e kind;
    logic [1:0] sizeTag;
  } strobe_t;

endpackage

// File: rtl/addr_gen_ctrl.sv
module addr_gen_ctrl
  import addr_gen_pkg::*;
#(
  parameter int NREG  = 31,
  parameter int NCIRC = 4,
  parameter int IW    = 5
) (
  input  logic          reqValid,
  input  logic [IW-1:0] reqPtr,
  input  logic          reqModSel,
  input  logic [1:0]    reqMode,
  input  logic [1:0]    reqUpd,
  input  logic [1:0]    reqSize,
  output strobe_t       strobe
);

  localparam logic [IW-1:0] NREG_IDX  = IW'(NREG);
  localparam logic [IW-1:0] NCIRC_IDX = IW'(NCIRC);

  logic ptrInFile;
  logic ptrHasRing;

  assign ptrInFile  = reqPtr < NREG_IDX;
  assign ptrHasRing = reqPtr < NCIRC_IDX;

  always_comb begin
    strobe           = '0;
    strobe.fire      = reqValid;
    strobe.useRegMod = reqModSel;
    unique case (addrMode_e'(reqMode))
      MODE_DIRECT: begin strobe.emitOld = 1'b1; strobe.writeBack = 1'b0; end
      MODE_INDEX:  begin strobe.emitOld = 1'b0; strobe.writeBack = 1'b0; end
      MODE_PRE:    begin strobe.emitOld = 1'b0; strobe.writeBack = 1'b1; end
      MODE_POST:   begin strobe.emitOld = 1'b1; strobe.writeBack = 1'b1; end
      default:     begin strobe.emitOld = 1'b1; strobe.writeBack = 1'b0; end
    endcase
    strobe.writeBack = strobe.writeBack & reqValid & ptrInFile;
    unique case (updKind_e'(reqUpd))
      UPD_CIRC:   strobe.kind = ptrHasRing ? UPD_CIRC : UPD_LINEAR;
      UPD_BITREV: strobe.kind = UPD_BITREV;
      default:    strobe.kind = UPD_LINEAR;
    endcase
    strobe.sizeTag = (reqSize == 2'b11) ? 2'b10 : reqSize;
  end

endmodule

// File: rtl/addr_gen_update.sv
module addr_gen_update
  import addr_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input  updKind_e      kind,
  input  logic [AW-1:0] ptrVal,
  input  logic [AW-1:0] modVal,
  input  logic [AW-1:0] baseVal,
  input  logic [AW-1:0] lenVal,
  output logic [AW-1:0] nextPtr
);

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [AW-1:0] linSum;
  logic [AW-1:0] revSum;
  logic [AW-1:0] ringOff;
  logic [AW:0]   ringRaw;
  logic [AW:0]   ringFix;
  logic [AW-1:0] ringSum;

  assign linSum  = ptrVal + modVal;
  // reversed carry: reverse operands, add normally, reverse back
  assign revSum  = flip(flip(ptrVal) + flip(modVal));

  // circular update done on the offset inside the buffer
  assign ringOff = ptrVal - baseVal;
  assign ringRaw = {1'b0, ringOff} + {modVal[AW-1], modVal};

  always_comb begin
    if (ringRaw[AW])
      ringFix = ringRaw + {1'b0, lenVal};
    else if (ringRaw >= {1'b0, lenVal})
      ringFix = ringRaw - {1'b0, lenVal};
    else
      ringFix = ringRaw;
  end

  assign ringSum = baseVal + ringFix[AW-1:0];

  always_comb begin
    unique case (kind)
      UPD_CIRC:   nextPtr = ringSum;
      UPD_BITREV: nextPtr = revSum;
      default:    nextPtr = linSum;
    endcase
  end

endmodule

// File: rtl/addr_gen_datapath.sv
module addr_gen_datapath
  import addr_gen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 31,
  parameter int NCIRC = 4,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [AW-1:0] wrData,
  input  logic [IW-1:0] reqPtr,
  input  logic [IW-1:0] reqModIdx,
  input  logic [AW-1:0] reqImm,
  input  strobe_t       strobe,
  output logic          addrValid,
  output logic [AW-1:0] addrOut,
  output logic [1:0]    addrSize
);

  localparam int            BASE_OFF = NREG - 2 * NCIRC;
  localparam int            LEN_OFF  = NREG - NCIRC;
  localparam logic [IW-1:0] NREG_IDX = IW'(NREG);

  logic [AW-1:0] regFile [NREG];

  function automatic logic [AW-1:0] readReg(input logic [IW-1:0] idx);
    logic [AW-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i)) v = regFile[i];
    return v;
  endfunction

  logic [IW-1:0] baseIdx;
  logic [IW-1:0] lenIdx;
  logic [AW-1:0] ptrVal;
  logic [AW-1:0] modVal;
  logic [AW-1:0] baseVal;
  logic [AW-1:0] lenVal;
  logic [AW-1:0] nextPtr;
  logic [AW-1:0] emitVal;
  logic          loadOk;

  assign baseIdx = IW'(BASE_OFF) + reqPtr;
  assign lenIdx  = IW'(LEN_OFF) + reqPtr;
  assign ptrVal  = readReg(reqPtr);
  assign modVal  = strobe.useRegMod ? readReg(reqModIdx) : reqImm;
  assign baseVal = readReg(baseIdx);
  assign lenVal  = readReg(lenIdx);
  assign loadOk  = wrEn && (wrIdx < NREG_IDX);

  addr_gen_update #(.AW(AW)) updUnit (
    .kind    (strobe.kind),
    .ptrVal  (ptrVal),
    .modVal  (modVal),
    .baseVal (baseVal),
    .lenVal  (lenVal),
    .nextPtr (nextPtr)
  );

  assign emitVal = strobe.emitOld ? ptrVal : nextPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      addrOut   <= '0;
      addrSize  <= '0;
    end else begin
      addrValid <= strobe.fire;
      if (strobe.fire) begin
        addrOut  <= emitVal;
        addrSize <= strobe.sizeTag;
      end
    end
  end

  // per-entry write: write-back has priority over a load
  for (genvar g = 0; g < NREG; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (strobe.writeBack && reqPtr == IW'(g))
        regFile[g] <= nextPtr;
      else if (loadOk && wrIdx == IW'(g))
        regFile[g] <= wrData;
    end
  end

endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import addr_gen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 31,
  parameter int NCIRC = 4,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [AW-1:0] wrData,
  input  logic          reqValid,
  input  logic [IW-1:0] reqPtr,
  input  logic          reqModSel,
  input  logic [IW-1:0] reqModIdx,
  input  logic [AW-1:0] reqImm,
  input  logic [1:0]    reqMode,
  input  logic [1:0]    reqUpd,
  input  logic [1:0]    reqSize,
  output logic          addrValid,
  output logic [AW-1:0] addrOut,
  output logic [1:0]    addrSize
);

  strobe_t strobe;

  addr_gen_ctrl #(.NREG(NREG), .NCIRC(NCIRC), .IW(IW)) ctrl (
    .reqValid  (reqValid),
    .reqPtr    (reqPtr),
    .reqModSel (reqModSel),
    .reqMode   (reqMode),
    .reqUpd    (reqUpd),
    .reqSize   (reqSize),
    .strobe    (strobe)
  );

  addr_gen_datapath #(.AW(AW), .NREG(NREG), .NCIRC(NCIRC), .IW(IW)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .reqPtr    (reqPtr),
    .reqModIdx (reqModIdx),
    .reqImm    (reqImm),
    .strobe    (strobe),
    .addrValid (addrValid),
    .addrOut   (addrOut),
    .addrSize  (addrSize)
  );

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          reqValid,
  input logic [IW-1:0] reqPtr,
  input logic          reqModSel,
  input logic [AW-1:0] reqImm,
  input logic [1:0]    reqMode,
  input logic [1:0]    reqUpd,
  input logic [1:0]    reqSize,
  input logic          addrValid,
  input logic [AW-1:0] addrOut,
  input logic [1:0]    addrSize
);

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rstN) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic linPost;
  logic directReq;
  assign linPost   = reqValid && reqMode == 2'b11 && reqUpd == 2'b00 && !reqModSel
                     && reqPtr != IW'(31);
  assign directReq = reqValid && reqMode == 2'b00;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0) |-> (addrValid == $past(reqValid)));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && !$past(reqValid)) |-> ($stable(addrOut) && $stable(addrSize)));

  // R11
  size_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && addrValid) |->
      (addrSize == (($past(reqSize) == 2'b11) ? 2'b10 : $past(reqSize))));

  // R6
  post_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && $past(linPost) && $past(linPost, 2) && $past(reqPtr) == $past(reqPtr, 2))
      |-> (addrOut == $past(addrOut) + $past(reqImm, 2)));

  // R4
  direct_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && $past(directReq) && $past(directReq, 2)
      && $past(reqPtr) == $past(reqPtr, 2) && !$past(wrEn, 2))
      |-> (addrOut == $past(addrOut)));

endmodule

bind addr_gen addr_gen_chk #(.AW(AW), .IW(IW)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .reqValid  (reqValid),
  .reqPtr    (reqPtr),
  .reqModSel (reqModSel),
  .reqImm    (reqImm),
  .reqMode   (reqMode),
  .reqUpd    (reqUpd),
  .reqSize   (reqSize),
  .addrValid (addrValid),
  .addrOut   (addrOut),
  .addrSize  (addrSize)
);

// File: tb/addr_gen_test.sv
module addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [4:0]  reqPtr = '0;
  logic        reqModSel = 1'b0;
  logic [4:0]  reqModIdx = '0;
  logic [31:0] reqImm = '0;
  logic [1:0]  reqMode = '0;
  logic [1:0]  reqUpd = '0;
  logic [1:0]  reqSize = '0;
  logic        addrValid;
  logic [31:0] addrOut;
  logic [1:0]  addrSize;

  always #5 clk = ~clk;

  addr_gen uut (.*);

  typedef struct {
    logic [31:0] a;
    logic [1:0]  s;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] model [32];
  int          nCmp = 0;
  int          nBad = 0;
  logic        running = 1'b0;
  logic        done = 1'b0;
  logic        pendLoad = 1'b0;
  logic [4:0]  pendIdx = '0;
  logic [31:0] pendVal = '0;
  logic [31:0] lastAddr = '0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] revAdd(input logic [31:0] p, input logic [31:0] m);
    logic [31:0] s;
    logic c;
    c = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      s[i] = p[i] ^ m[i] ^ c;
      c = (p[i] & m[i]) | (c & (p[i] ^ m[i]));
    end
    return s;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (running && addrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected valid", addrOut, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(addrOut == e.a, e.tag, addrOut, e.a);
        check(addrSize == e.s, {e.tag, " size R11"}, 32'(addrSize), 32'(e.s));
      end
    end
  end

  task automatic loadReg(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    reqValid = 1'b0;
    wrEn = 1'b1; wrIdx = idx; wrData = val;
    if (idx != 5'd31) model[idx] = val;
  endtask

  task automatic req(input logic [4:0] ptr, input logic modSel, input logic [4:0] modIdx,
                     input logic [31:0] imm, input logic [1:0] mode, input logic [1:0] upd,
                     input logic [1:0] size, input string tag);
    logic [31:0] p, m, nv, outv, b, l;
    longint t;
    exp_t e;
    @(negedge clk);
    p = model[ptr];
    m = modSel ? model[modIdx] : imm;
    nv = p + m;
    if (upd == 2'b01 && ptr < 5'd4) begin
      b = model[23 + ptr];
      l = model[27 + ptr];
      t = longint'(p - b) + longint'($signed(m));
      if (t < 0) t = t + longint'(l);
      else if (t >= longint'(l)) t = t - longint'(l);
      nv = b + t[31:0];
    end else if (upd == 2'b10) begin
      nv = revAdd(p, m);
    end
    outv = (mode == 2'b00 || mode == 2'b11) ? p : nv;
    e.a = outv;
    e.s = (size == 2'b11) ? 2'b10 : size;
    e.tag = tag;
    expQ.push_back(e);
    lastAddr = outv;
    wrEn = pendLoad; wrIdx = pendIdx; wrData = pendVal;
    if (pendLoad && pendIdx != 5'd31) model[pendIdx] = pendVal;
    if (mode[1] && ptr != 5'd31) model[ptr] = nv;
    pendLoad = 1'b0;
    reqValid = 1'b1; reqPtr = ptr; reqModSel = modSel; reqModIdx = modIdx;
    reqImm = imm; reqMode = mode; reqUpd = upd; reqSize = size;
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    check(addrValid == 1'b0, {tag, " valid low R1"}, 32'(addrValid), 32'd0);
    check(addrOut == lastAddr, {tag, " addr held R1"}, addrOut, lastAddr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(addrValid == 1'b0, "R13 reset valid", 32'(addrValid), 32'd0);
    check(addrOut == 32'd0, "R13 reset addr", addrOut, 32'd0);
    check(addrSize == 2'd0, "R13 reset size", 32'(addrSize), 32'd0);
    rstN = 1'b1;
    running = 1'b1;

    req(5'd7, 0, 0, 0, 2'b00, 2'b00, 2'b00, "R13 register cleared");
    loadReg(5'd0, 32'd100);
    loadReg(5'd5, 32'd3);
    loadReg(5'd24, 32'd200);
    loadReg(5'd28, 32'd10);
    loadReg(5'd1, 32'd205);
    loadReg(5'd6, 32'd50);

    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R2 R4 direct after load");
    req(5'd0, 0, 0, 32'd8, 2'b01, 2'b00, 2'b00, "R4 R7 indexed");
    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R4 indexed leaves pointer");
    req(5'd0, 0, 0, 32'd4, 2'b10, 2'b00, 2'b00, "R5 pre-modify");
    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R5 pre written back");
    req(5'd0, 1, 5'd5, 32'd0, 2'b11, 2'b00, 2'b00, "R3 R6 post register modifier");
    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R6 post written back");
    idleCheck("gap1");

    req(5'd1, 0, 0, 32'd4, 2'b11, 2'b01, 2'b00, "R8 circular post 1");
    req(5'd1, 0, 0, 32'd4, 2'b11, 2'b01, 2'b00, "R8 circular post 2");
    req(5'd1, 0, 0, 32'hFFFF_FFFB, 2'b11, 2'b01, 2'b00, "R8 circular wrap up");
    req(5'd1, 0, 0, 32'd2, 2'b10, 2'b01, 2'b00, "R8 circular wrap down then pre at top");
    req(5'd1, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R8 circular pointer value");
    req(5'd6, 0, 0, 32'd30, 2'b11, 2'b01, 2'b00, "R9 circular fallback post");
    req(5'd6, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R9 fallback linear result");

    for (int k = 0; k < 8; k++)
      req(5'd2, 0, 0, 32'd4, 2'b11, 2'b10, 2'b00, $sformatf("R10 bit-reverse step %0d", k));
    req(5'd2, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R10 bit-reverse wraps to zero");

    req(5'd0, 0, 0, 32'hFFFF_FFFC, 2'b10, 2'b11, 2'b00, "R7 spare code linear");
    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b01, "R11 dual");
    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b10, "R11 quad");
    req(5'd0, 0, 0, 32'd0, 2'b00, 2'b00, 2'b11, "R11 reserved as quad");
    idleCheck("gap2");

    loadReg(5'd31, 32'd999);
    req(5'd31, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R2 index 31 reads zero");
    req(5'd0, 1, 5'd31, 32'd0, 2'b01, 2'b00, 2'b00, "R2 index 31 modifier zero");

    loadReg(5'd3, 32'd10);
    pendLoad = 1'b1; pendIdx = 5'd3; pendVal = 32'd50;
    req(5'd3, 0, 0, 32'd1, 2'b10, 2'b00, 2'b00, "R12 pre with colliding load");
    req(5'd3, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R12 write-back wins");
    pendLoad = 1'b1; pendIdx = 5'd4; pendVal = 32'd77;
    req(5'd3, 0, 0, 32'd1, 2'b11, 2'b00, 2'b00, "R12 post with other load");
    req(5'd4, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R12 other load taken");
    req(5'd3, 0, 0, 32'd0, 2'b00, 2'b00, 2'b00, "R12 write-back taken");
    idleCheck("gap3");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 all requests answered", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule